// File: doc/BRIEF.md
# Five-Channel Prescaled Down-Counter Timer

This block holds a bank of independent down-counting timers (five by default) behind a simple 32-bit register port. Each channel has a control word, a reload value and a read-only live count. A channel counts down by one for every (prescale + 1) pulses on the shared reference tick input. When it reaches zero it raises its bit in a shared status word. It then either reloads and keeps running (repeat mode) or stops (single mode). Each channel drives its own interrupt line, qualified by that channel's interrupt-enable bit.

Software starts and stops a channel through its enable bit. Stopping freezes the count and starting again resumes from the frozen value. A reload-strobe bit in the control word forces the count back to the reload value. The status word is cleared by writing ones. A watchdog control word is present only as a fixed, read-only value. Every register access is acknowledged one cycle later, and read data appears in that same cycle.

Each channel is a two-state machine: `ST_IDLE` (stopped) and `ST_RUN` (counting). The transitions are:
- `T_START`: an enable write with the reload strobe clear takes `ST_IDLE` to `ST_RUN`.
- `T_STOP`: a control write whose effective enable is 0 (including any write with the reload strobe set) takes `ST_RUN` to `ST_IDLE`.
- `T_SINGLE_END`: expiry in single mode takes `ST_RUN` to `ST_IDLE`.
- `T_HOLD`: any other cycle leaves the state unchanged.

Top module: `mtimer_ctrl`

## Requirements
- R1: After reset every control word reads 0x00000005, every reload value and live count reads 0, the status word reads 0, the watchdog word reads 0x00000400, and all interrupt lines are low.
- R2: Control word layout: bit 31 and bit 28 are spare storage that reads back as written; bit 30 is enable; bit 29 is interrupt enable; bit 27 is repeat mode; bit 26 is the reload strobe; bit 25 is the read-only running flag; bits 7:0 are the prescale value. Writes to bits 24:8 are dropped and read as 0. A written value of bit 25 is ignored.
- R3: A control write with both the reload strobe and enable set acts as if enable were 0. The reload strobe always reads back as 0.
- R4: A control write with the reload strobe set copies the reload value into the live count, restarts the prescale phase, and leaves the channel stopped.
- R5: Setting enable sets the running flag and starts counting from the present count without losing it. Clearing enable clears the running flag and freezes the count. The count then stays frozen across any number of ticks.
- R6: A running channel decrements once per (prescale + 1) ticks. A control write that changes the prescale value keeps the live count and restarts the prescale phase from zero.
- R7: A decrement from a count of 1 (or a tick step at a count of 0) sets the channel's status bit. In repeat mode the count reloads and the channel keeps running. In single mode the count stays 0 and enable and the running flag clear.
- R8: Writing the status word at byte offset 0x18 clears each bit written as 1. Bits written as 0 keep their value. If an expiry and a clear of the same bit fall in one cycle, the bit stays set.
- R9: Each interrupt line is high exactly when its channel's interrupt enable and status bit are both set.
- R10: A control write that stops a running channel whose count is already 0 performs expiry at once. It sets the status bit and, if the written mode is repeat, reloads the count.
- R11: Writes to the live count registers and to the watchdog word at 0x1C have no effect. Reads from unmapped or non-word-aligned byte addresses return 0, and writes to them change nothing.
- R12: Writing a channel's reload value also loads it into the live count at once and restarts the prescale phase. A running channel keeps running from the new value.
- R13: `ack` is high in the cycle after any access and low otherwise. `rdata` carries the read value in the cycle `ack` is high.
- R14: Channel k's control word sits at byte offset 32*(k/2) + 4*(k mod 2). Its reload value sits 8 bytes above that and its live count 16 bytes above.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Reference tick, one cycle wide per pulse |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | AW (12) | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| ack | output | 1 | Access acknowledge, one cycle after a strobe |
| irq | output | NCH (5) | Per-channel interrupt lines |

## Verification
The assertions assume that `wr_en` and `rd_en` target a single address per cycle. They also assume that a channel's count changes only in a cycle with a write or a tick, so `tick` must be a clean single-cycle level sampled on the clock. The bench keeps to this by driving every bus access and every tick on its own falling-edge-aligned cycle, never overlapping the two. The random rounds always reload a channel before enabling it, so the prescale phase starts from zero and the expected count follows from the tick count alone.

// File: rtl/mtimer_pkg.sv
`timescale 1ns/1ps
package mtimer_pkg;
    localparam int DW = 32;

    // control word bit positions
    localparam int B_SPH  = 31;
    localparam int B_EN   = 30;
    localparam int B_IE   = 29;
    localparam int B_SPL  = 28;
    localparam int B_PER  = 27;
    localparam int B_CRST = 26;
    localparam int B_ACT  = 25;

    localparam logic [7:0]    PSC_RST  = 8'd5;
    localparam logic [DW-1:0] WDOG_RST = 32'h0000_0400;

    localparam int OFS_STAT = 32'h18;
    localparam int OFS_WDOG = 32'h1C;
    localparam int OFS_INIT = 8;
    localparam int OFS_CUR  = 16;

    typedef enum logic [2:0] {
        HIT_NONE,
        HIT_CTRL,
        HIT_INIT,
        HIT_CUR,
        HIT_STAT,
        HIT_WDOG
    } hit_e;

    typedef enum logic {
        ST_IDLE,
        ST_RUN
    } run_e;

    // byte offset of a channel's control word; pairs of channels per 32-byte group
    function automatic int chan_base(int idx);
        return (idx / 2) * 32 + (idx % 2) * 4;
    endfunction
endpackage

// File: rtl/mtimer_decode.sv
`timescale 1ns/1ps
module mtimer_decode
    import mtimer_pkg::*;
#(
    parameter int NCH = 5,
    parameter int AW  = 12,
    localparam int CIW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [AW-1:0]  addr,
    output hit_e           kind,
    output logic [CIW-1:0] chan
);
    always_comb begin
        kind = HIT_NONE;
        chan = '0;
        if (addr[1:0] == 2'b00) begin
            if (addr == AW'(OFS_STAT)) begin
                kind = HIT_STAT;
            end else if (addr == AW'(OFS_WDOG)) begin
                kind = HIT_WDOG;
            end
            for (int i = 0; i < NCH; i++) begin
                if (addr == AW'(chan_base(i))) begin
                    kind = HIT_CTRL;
                    chan = CIW'(i);
                end
                if (addr == AW'(chan_base(i) + OFS_INIT)) begin
                    kind = HIT_INIT;
                    chan = CIW'(i);
                end
                if (addr == AW'(chan_base(i) + OFS_CUR)) begin
                    kind = HIT_CUR;
                    chan = CIW'(i);
                end
            end
        end
    end
endmodule

// File: rtl/mtimer_chan.sv
`timescale 1ns/1ps
module mtimer_chan
    import mtimer_pkg::*;
#(
    parameter int CW = 32,
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          ctrl_we,
    input  logic          init_we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] ctrl_rd,
    output logic [CW-1:0] init_rd,
    output logic [CW-1:0] cnt_rd,
    output logic          ie,
    output logic          run,
    output logic          expire
);
    localparam logic [PW-1:0] PSC_INIT = PW'(PSC_RST);

    run_e          state_q, state_d;
    logic          ie_q, per_q, sph_q, spl_q;
    logic [PW-1:0] psc_q, phase_q;
    logic [CW-1:0] init_q, cnt_q;

    // write field decode; reload strobe overrides enable
    logic          w_crst, w_en;
    logic [PW-1:0] w_psc;
    logic          busy_wr, step, adv, step_exp, stop_exp;

    assign w_crst = wdata[B_CRST];
    assign w_en   = wdata[B_EN] & ~w_crst;
    assign w_psc  = wdata[PW-1:0];

    assign busy_wr  = ctrl_we | init_we;
    assign step     = tick & (state_q == ST_RUN) & ~busy_wr & (phase_q == psc_q);
    assign adv      = tick & (state_q == ST_RUN) & ~busy_wr & (phase_q != psc_q);
    assign step_exp = step & (cnt_q <= CW'(1));
    assign stop_exp = ctrl_we & ~w_crst & ~w_en & (state_q == ST_RUN) & (cnt_q == '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ctrl_we && w_en) begin
                    state_d = ST_RUN;              // T_START
                end
            end
            ST_RUN: begin
                if (ctrl_we && !w_en) begin
                    state_d = ST_IDLE;             // T_STOP
                end else if (step_exp && !per_q) begin
                    state_d = ST_IDLE;             // T_SINGLE_END
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // datapath and fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie_q    <= 1'b0;
            per_q   <= 1'b0;
            sph_q   <= 1'b0;
            spl_q   <= 1'b0;
            psc_q   <= PSC_INIT;
            phase_q <= '0;
            init_q  <= '0;
            cnt_q   <= '0;
        end else if (ctrl_we) begin
            ie_q  <= wdata[B_IE];
            per_q <= wdata[B_PER];
            sph_q <= wdata[B_SPH];
            spl_q <= wdata[B_SPL];
            psc_q <= w_psc;
            if (w_crst) begin
                cnt_q   <= init_q;
                phase_q <= '0;
            end else begin
                if (w_psc != psc_q) begin
                    phase_q <= '0;
                end
                if (stop_exp && wdata[B_PER]) begin
                    cnt_q <= init_q;
                end
            end
        end else if (init_we) begin
            init_q  <= wdata[CW-1:0];
            cnt_q   <= wdata[CW-1:0];
            phase_q <= '0;
        end else if (step) begin
            phase_q <= '0;
            if (cnt_q <= CW'(1)) begin
                cnt_q <= per_q ? init_q : '0;
            end else begin
                cnt_q <= cnt_q - CW'(1);
            end
        end else if (adv) begin
            phase_q <= phase_q + PW'(1);
        end
    end

    // outputs
    always_comb begin
        ctrl_rd          = '0;
        ctrl_rd[B_SPH]   = sph_q;
        ctrl_rd[B_EN]    = (state_q == ST_RUN);
        ctrl_rd[B_IE]    = ie_q;
        ctrl_rd[B_SPL]   = spl_q;
        ctrl_rd[B_PER]   = per_q;
        ctrl_rd[B_ACT]   = (state_q == ST_RUN);
        ctrl_rd[PW-1:0]  = psc_q;
    end

    assign init_rd = init_q;
    assign cnt_rd  = cnt_q;
    assign ie      = ie_q;
    assign run     = (state_q == ST_RUN);
    assign expire  = step_exp | stop_exp;
endmodule

// File: rtl/mtimer_ctrl.sv
`timescale 1ns/1ps
module mtimer_ctrl
    import mtimer_pkg::*;
#(
    parameter int NCH = 5,
    parameter int AW  = 12,
    parameter int CW  = 32,
    parameter int PW  = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic           wr_en,
    input  logic           rd_en,
    input  logic [AW-1:0]  addr,
    input  logic [DW-1:0]  wdata,
    output logic [DW-1:0]  rdata,
    output logic           ack,
    output logic [NCH-1:0] irq
);
    localparam int CIW = (NCH > 1) ? $clog2(NCH) : 1;

    hit_e           kind;
    logic [CIW-1:0] chan;

    logic [DW-1:0]  ctrl_rd  [NCH];
    logic [CW-1:0]  init_rd  [NCH];
    logic [CW-1:0]  cnt_vec  [NCH];
    logic [NCH-1:0] ie_vec, run_vec, exp_vec, stat_q, stat_clr;

    mtimer_decode #(.NCH(NCH), .AW(AW)) u_dec (
        .addr (addr),
        .kind (kind),
        .chan (chan)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic ctrl_we_g, init_we_g;
        assign ctrl_we_g = wr_en && (kind == HIT_CTRL) && (chan == CIW'(g));
        assign init_we_g = wr_en && (kind == HIT_INIT) && (chan == CIW'(g));

        mtimer_chan #(.CW(CW), .PW(PW)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick),
            .ctrl_we (ctrl_we_g),
            .init_we (init_we_g),
            .wdata   (wdata),
            .ctrl_rd (ctrl_rd[g]),
            .init_rd (init_rd[g]),
            .cnt_rd  (cnt_vec[g]),
            .ie      (ie_vec[g]),
            .run     (run_vec[g]),
            .expire  (exp_vec[g])
        );
    end

    // shared status word: set wins over a same-cycle clear
    assign stat_clr = (wr_en && kind == HIT_STAT) ? wdata[NCH-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= (stat_q & ~stat_clr) | exp_vec;
        end
    end

    assign irq = ie_vec & stat_q;

    // registered read path and acknowledge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
            ack   <= 1'b0;
        end else begin
            ack <= rd_en | wr_en;
            if (rd_en) begin
                unique case (kind)
                    HIT_CTRL: rdata <= ctrl_rd[chan];
                    HIT_INIT: rdata <= DW'(init_rd[chan]);
                    HIT_CUR:  rdata <= DW'(cnt_vec[chan]);
                    HIT_STAT: rdata <= DW'(stat_q);
                    HIT_WDOG: rdata <= WDOG_RST;
                    default:  rdata <= '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/mtimer_chk.sv
`timescale 1ns/1ps
module mtimer_chk
    import mtimer_pkg::*;
#(
    parameter int NCH = 5,
    parameter int AW  = 12,
    parameter int CW  = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic           tick,
    input logic           wr_en,
    input logic           rd_en,
    input logic [AW-1:0]  addr,
    input logic [DW-1:0]  wdata,
    input logic           ack,
    input logic [NCH-1:0] irq,
    input logic [NCH-1:0] run_vec,
    input logic [NCH-1:0] stat_q,
    input logic [CW-1:0]  cnt_vec [NCH]
);
    AST_ACK_AFTER_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en || wr_en) |=> ack); // R13
    AST_ACK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en || wr_en) |=> !ack); // R13

    for (genvar g = 0; g < NCH; g++) begin : g_a
        AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (!wr_en && !run_vec[g]) |=> $stable(cnt_vec[g])); // R5
        AST_NO_TICK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (!wr_en && !tick) |=> $stable(cnt_vec[g])); // R6
        AST_STATUS_W1C: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(stat_q[g]) |-> $past(wr_en && addr == AW'(OFS_STAT) && wdata[g])); // R8
        AST_IRQ_CAUSED: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq[g]) |-> $past(wr_en || tick)); // R9
        AST_RUN_DROP_CAUSED: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(run_vec[g]) |-> $past(wr_en || tick)); // R7
    end
endmodule

bind mtimer_ctrl mtimer_chk #(.NCH(NCH), .AW(AW), .CW(CW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wdata   (wdata),
    .ack     (ack),
    .irq     (irq),
    .run_vec (run_vec),
    .stat_q  (stat_q),
    .cnt_vec (cnt_vec)
);

// File: tb/mtimer_ctrl_test.sv
`timescale 1ns/1ps
module mtimer_ctrl_test;
    localparam int NCH = 5;
    localparam int AW  = 12;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           tick = 1'b0;
    logic           wr_en = 1'b0;
    logic           rd_en = 1'b0;
    logic [AW-1:0]  addr = '0;
    logic [31:0]    wdata = '0;
    logic [31:0]    rdata;
    logic           ack;
    logic [NCH-1:0] irq;

    int errs = 0;
    int checks = 0;

    int unsigned c_v [NCH];
    int unsigned p_v [NCH];
    int unsigned pe_v [NCH];
    int unsigned ie_v [NCH];

    always #2.5 clk = ~clk;

    mtimer_ctrl #(.NCH(NCH), .AW(AW)) uut (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .ack   (ack),
        .irq   (irq)
    );

    function automatic logic [AW-1:0] a_ctrl(int k);
        return AW'((k / 2) * 32 + (k % 2) * 4);
    endfunction
    function automatic logic [AW-1:0] a_init(int k);
        return a_ctrl(k) + AW'(8);
    endfunction
    function automatic logic [AW-1:0] a_cur(int k);
        return a_ctrl(k) + AW'(16);
    endfunction
    localparam logic [AW-1:0] A_STAT = 12'h018;
    localparam logic [AW-1:0] A_WDOG = 12'h01C;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [AW-1:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        if (ack !== 1'b1) begin
            checks++; errs++;
            $display("FAIL R13: actual ack=%b expected=1", ack);
        end
        d = rdata;
    endtask

    task automatic rchk(string req, logic [AW-1:0] a, logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(req, d, exp);
    endtask

    task automatic ticks(int n);
        for (int t = 0; t < n; t++) begin
            @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errs++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int unsigned seed;
        seed = $urandom(32'd4711);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 irq", 32'(irq), 32'h0);
        for (int i = 0; i < NCH; i++) begin
            rchk("R1 ctrl", a_ctrl(i), 32'h0000_0005);
            rchk("R1 init", a_init(i), 32'h0);
            rchk("R1 cur", a_cur(i), 32'h0);
        end
        rchk("R1 status", A_STAT, 32'h0);
        rchk("R1 wdog", A_WDOG, 32'h0000_0400);

        // R13 ack drops in an idle cycle
        @(negedge clk);
        chk("R13 ack idle", 32'(ack), 32'h0);

        // R2 reserved and running-flag bits dropped, spares kept
        wr(a_ctrl(0), 32'hA3FF_FF12);
        rchk("R2 ctrl mask", a_ctrl(0), 32'hA000_0012);

        // R12/R14 reload write, R5 start, R6 prescale 0
        wr(a_init(0), 32'd10);
        rchk("R12 init load", a_cur(0), 32'd10);
        wr(a_ctrl(0), 32'h4000_0000);
        rchk("R5 running flag", a_ctrl(0), 32'h4200_0000);
        ticks(3);
        rchk("R6 psc0 rate", a_cur(0), 32'd7);

        // R3/R4 reload strobe with enable
        wr(a_ctrl(0), 32'h4400_0000);
        rchk("R3 enable dropped", a_ctrl(0), 32'h0000_0000);
        rchk("R4 reload", a_cur(0), 32'd10);
        ticks(3);
        rchk("R4 stopped", a_cur(0), 32'd10);

        // R5 pause / resume
        wr(a_ctrl(0), 32'h4000_0000);
        ticks(4);
        rchk("R5 run", a_cur(0), 32'd6);
        wr(a_ctrl(0), 32'h0000_0000);
        ticks(5);
        rchk("R5 frozen", a_cur(0), 32'd6);
        wr(a_ctrl(0), 32'h4000_0000);
        ticks(2);
        rchk("R5 resumed", a_cur(0), 32'd4);

        // R6 prescale rate and phase restart on change
        wr(a_ctrl(0), 32'h4000_0002);
        ticks(7);
        rchk("R6 psc2 rate", a_cur(0), 32'd2);
        wr(a_ctrl(0), 32'h4000_0001);
        rchk("R6 count kept", a_cur(0), 32'd2);
        ticks(1);
        rchk("R6 phase restart", a_cur(0), 32'd2);
        ticks(1);
        rchk("R6 psc1 step", a_cur(0), 32'd1);

        // R7 single mode expiry, R9 irq, R8 write-one-to-clear
        wr(a_init(0), 32'd3);
        wr(a_ctrl(0), 32'h6000_0000);
        ticks(3);
        rchk("R7 single count", a_cur(0), 32'd0);
        rchk("R7 single stop", a_ctrl(0), 32'h2000_0000);
        rchk("R7 status", A_STAT, 32'h1);
        chk("R9 irq on", 32'(irq), 32'h1);
        ticks(2);
        rchk("R7 stays zero", a_cur(0), 32'd0);
        wr(A_STAT, 32'h0);
        rchk("R8 zero write", A_STAT, 32'h1);
        wr(A_STAT, 32'h1E);
        rchk("R8 other bits", A_STAT, 32'h1);
        wr(A_STAT, 32'h1);
        rchk("R8 cleared", A_STAT, 32'h0);
        chk("R9 irq off", 32'(irq), 32'h0);

        // R7 repeat mode on channel 2, R9 gating by enable
        wr(a_init(2), 32'd4);
        wr(a_ctrl(2), 32'h4800_0000);
        ticks(10);
        rchk("R7 repeat count", a_cur(2), 32'd2);
        rchk("R7 repeat status", A_STAT, 32'h4);
        chk("R9 gated", 32'(irq), 32'h0);
        wr(a_ctrl(2), 32'h6800_0000);
        chk("R9 enabled", 32'(irq), 32'h4);
        rchk("R7 repeat runs", a_ctrl(2), 32'h6A00_0000);
        wr(a_ctrl(2), 32'h0800_0000);
        wr(A_STAT, 32'h4);

        // R10 stop at zero count on channel 1
        wr(a_ctrl(1), 32'h4000_0000);
        wr(a_ctrl(1), 32'h0000_0000);
        rchk("R10 expiry on stop", A_STAT, 32'h2);
        chk("R10 irq gated", 32'(irq), 32'h0);
        wr(A_STAT, 32'h2);

        // R11 ignored writes and unmapped reads
        wr(a_cur(0), 32'hDEAD_BEEF);
        rchk("R11 cur ro", a_cur(0), 32'd0);
        wr(A_WDOG, 32'h0);
        rchk("R11 wdog ro", A_WDOG, 32'h0000_0400);
        wr(12'h038, 32'hFFFF_FFFF);
        rchk("R11 unmapped", 12'h038, 32'h0);
        rchk("R11 unmapped hi", 12'h05C, 32'h0);
        wr(12'h009, 32'h55);
        rchk("R11 misaligned wr", a_init(0), 32'd3);
        rchk("R11 misaligned rd", 12'h009, 32'h0);

        // R12 reload write while running, channel 3
        wr(a_init(3), 32'd9);
        wr(a_ctrl(3), 32'h4000_0000);
        ticks(3);
        rchk("R12 before", a_cur(3), 32'd6);
        wr(a_init(3), 32'd20);
        rchk("R12 reload now", a_cur(3), 32'd20);
        ticks(1);
        rchk("R12 keeps running", a_cur(3), 32'd19);
        wr(a_ctrl(3), 32'h0);
        rchk("R14 init ch4", a_init(4), 32'd0);

        // random rounds across all channels
        for (int r = 0; r < 25; r++) begin
            int unsigned k;
            logic [31:0] est, eie, m;
            wr(A_STAT, 32'h1F);
            for (int i = 0; i < NCH; i++) begin
                c_v[i]  = 1 + ($urandom % 20);
                p_v[i]  = $urandom % 4;
                pe_v[i] = $urandom % 2;
                ie_v[i] = $urandom % 2;
                wr(a_init(i), c_v[i]);
                wr(a_ctrl(i), 32'h4000_0000 | (ie_v[i] << 29) | (pe_v[i] << 27) | p_v[i]);
            end
            k = $urandom % 61;
            ticks(int'(k));
            est = '0; eie = '0;
            for (int i = 0; i < NCH; i++) begin
                int unsigned dd, ec;
                logic expd, runn;
                dd = k / (p_v[i] + 1);
                expd = (dd >= c_v[i]);
                if (pe_v[i] != 0) ec = c_v[i] - (dd % c_v[i]);
                else ec = expd ? 0 : c_v[i] - dd;
                runn = (pe_v[i] != 0) || !expd;
                rchk("R6/R7 random count", a_cur(i), ec);
                rchk("R5/R7 random ctrl", a_ctrl(i),
                     (32'(runn) << 30) | (ie_v[i] << 29) | (pe_v[i] << 27) |
                     (32'(runn) << 25) | p_v[i]);
                est[i] = expd;
                eie[i] = ie_v[i][0];
            end
            rchk("R7 random status", A_STAT, est);
            chk("R9 random irq", 32'(irq), est & eie);
            m = $urandom % 32;
            wr(A_STAT, m);
            rchk("R8 random clear", A_STAT, est & ~m);
            for (int i = 0; i < NCH; i++) begin
                wr(a_ctrl(i), 32'h0);
            end
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule